// File: doc/BRIEF.md
# Grouped latched interrupt controller

This block collects interrupt events from three groups of sources (packet handling, modem, chip status) of eight sources each. A source sets its pending bit when its level rises. Pending bits are kept until the host clears them with a read. The active-low interrupt line is asserted while at least one pending source is allowed through both its group enable and its own enable.

The host can read and clear every group with one strobe, or one group at a time with a per-group strobe. The pending vector is the read data, valid in the cycle of the strobe, and the clear takes effect at the next clock edge. A live status vector shows the registered level of every source, whatever the enables are. A separate snapshot strobe copies the pending vector into a holding register for fast polling. It never clears anything and never releases the interrupt line. Enables gate only the output and never stop latching, so a masked event still shows once its enables are set.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: A source whose input is high in a cycle after being low in the previous cycle has its pending bit set after that clock edge.
- R2: A source held high, held low or falling never sets its pending bit.
- R3: irq_no is 0 when at least one pending bit has both its group enable and its source enable set, and 1 otherwise.
- R4: Clearing a group's enable bit grp_en_i[g] masks every source of group g from irq_no. The pending bits stay set.
- R5: Clearing a source's enable bit in src_en_i masks that source alone from irq_no.
- R6: A pulse on rd_all_i clears every pending bit in all groups at the next edge. pend_o in the strobe cycle holds the values being cleared.
- R7: A pulse on rd_grp_i[g] clears only the pending bits of group g (bits g*8 to g*8+7). The other groups keep their pending bits.
- R8: A rising edge that arrives in the same cycle as a clearing read leaves its pending bit set after the clear.
- R9: status_o shows each source's input level delayed by one clock, whatever the enables are.
- R10: A pulse on snap_rd_i loads snap_o with the pending vector of that cycle. It clears no pending bit and does not release irq_no.
- R11: After reset, pend_o, status_o and snap_o are 0 and irq_no is 1.
- R12: A source that rises while masked latches its pending bit anyway, and it drives irq_no low once its enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 24 | Source levels, group g in bits g*8+7:g*8 |
| grp_en_i | input | 3 | Group enables |
| src_en_i | input | 24 | Per-source enables |
| rd_all_i | input | 1 | Read-and-clear strobe for all groups |
| rd_grp_i | input | 3 | Read-and-clear strobe per group |
| snap_rd_i | input | 1 | Non-clearing snapshot strobe |
| pend_o | output | 24 | Pending bits (read data) |
| status_o | output | 24 | Live source levels |
| snap_o | output | 24 | Snapshot of pending bits |
| irq_no | output | 1 | Active-low interrupt |

## Verification
The bench sweeps every one of the 24 sources through a rising edge, all four combinations of group and source enable, a clear by group strobe or by the all-groups strobe, and a falling edge. A design that latched on level or on the falling edge, or that decoded the wrong group slice, would show a wrong pending bit. One that wired the enables the wrong way would show a wrong interrupt level.

The bench puts an event in the same cycle as a clear. A design that gave priority to the clear would lose that event. The bench checks that the snapshot strobe leaves pending bits and the interrupt line alone, because a design that shared the clear path would drop them. It also latches a source while it is masked, so a design that gated latching with the enables would never raise the interrupt when the source is later enabled.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int unsigned GIC_GRP_N = 3;
  localparam int unsigned GIC_GRP_W = 8;
  localparam int unsigned GIC_SRC_N = GIC_GRP_N * GIC_GRP_W;
endpackage

// File: rtl/gic_grp_latch.sv
module gic_grp_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] level_o
);
  logic [W-1:0] src_q, pend_q, rise_w;

  assign rise_w = src_i & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      // new edges win over a clear in the same cycle
      pend_q <= (pend_q & ~{W{clr_i}}) | rise_w;
    end
  end

  assign pend_o  = pend_q;
  assign level_o = src_q;

  a_r1_edge_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_w != '0) |=> ((pend_q & $past(rise_w)) == $past(rise_w)));

  a_r2_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == src_q) |=> ((pend_q & ~$past(pend_q)) == '0));

  a_r6_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && rise_w == '0) |=> (pend_q == '0));
endmodule

// File: rtl/gic_out_mask.sv
module gic_out_mask #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 8
) (
  input  logic [N*W-1:0] pend_i,
  input  logic [N*W-1:0] src_en_i,
  input  logic [N-1:0]   grp_en_i,
  output logic           irq_no
);
  logic [N-1:0] hit_w;

  for (genvar g = 0; g < N; g++) begin : g_grp
    assign hit_w[g] = grp_en_i[g] & (|(pend_i[g*W +: W] & src_en_i[g*W +: W]));
  end

  assign irq_no = ~(|hit_w);
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import gic_pkg::*;
#(
  parameter int unsigned GRP_N = GIC_GRP_N,
  parameter int unsigned GRP_W = GIC_GRP_W,
  localparam int unsigned SRC_N = GRP_N * GRP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_i,
  input  logic [GRP_N-1:0] grp_en_i,
  input  logic [SRC_N-1:0] src_en_i,
  input  logic             rd_all_i,
  input  logic [GRP_N-1:0] rd_grp_i,
  input  logic             snap_rd_i,
  output logic [SRC_N-1:0] pend_o,
  output logic [SRC_N-1:0] status_o,
  output logic [SRC_N-1:0] snap_o,
  output logic             irq_no
);
  logic [SRC_N-1:0] pend_w;
  logic [SRC_N-1:0] snap_q;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    gic_grp_latch #(.W(GRP_W)) u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[g*GRP_W +: GRP_W]),
      .clr_i  (rd_all_i | rd_grp_i[g]),
      .pend_o (pend_w[g*GRP_W +: GRP_W]),
      .level_o(status_o[g*GRP_W +: GRP_W])
    );

    a_r7_other_groups_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_all_i && !rd_grp_i[g]) |=>
        ((pend_o[g*GRP_W +: GRP_W] & $past(pend_o[g*GRP_W +: GRP_W]))
          == $past(pend_o[g*GRP_W +: GRP_W])));
  end

  gic_out_mask #(.N(GRP_N), .W(GRP_W)) u_mask (
    .pend_i  (pend_w),
    .src_en_i(src_en_i),
    .grp_en_i(grp_en_i),
    .irq_no  (irq_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (snap_rd_i) snap_q <= pend_w;
  end

  assign pend_o = pend_w;
  assign snap_o = snap_q;

  a_r3_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o == '0) |-> irq_no);

  a_r10_snap_keeps_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_rd_i && !rd_all_i && rd_grp_i == '0) |=>
      ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: tb/grouped_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module grouped_irq_ctrl_tb_top;
  localparam int GN = 3;
  localparam int GW = 8;
  localparam int SN = GN * GW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SN-1:0] src = '0, src_en = '0;
  logic [GN-1:0] grp_en = '0, rd_grp = '0;
  logic          rd_all = 1'b0, snap_rd = 1'b0;
  logic [SN-1:0] pend, status, snap;
  logic          irq_n;

  logic [SN-1:0] m_pend = '0, m_srcq = '0, m_snap = '0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grouped_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .grp_en_i(grp_en),
    .src_en_i(src_en), .rd_all_i(rd_all), .rd_grp_i(rd_grp),
    .snap_rd_i(snap_rd), .pend_o(pend), .status_o(status),
    .snap_o(snap), .irq_no(irq_n)
  );

  function automatic logic exp_irq_n();
    logic any = 1'b0;
    for (int g = 0; g < GN; g++)
      if (grp_en[g] && ((m_pend[g*GW +: GW] & src_en[g*GW +: GW]) != '0)) any = 1'b1;
    return ~any;
  endfunction

  // one clock edge, model updated from the requirements, returns at negedge
  task automatic cyc();
    logic [SN-1:0] clr;
    @(posedge clk);
    clr = '0;
    for (int g = 0; g < GN; g++)
      if (rd_all || rd_grp[g]) clr[g*GW +: GW] = '1;
    if (snap_rd) m_snap = m_pend;
    m_pend = (m_pend & ~clr) | (src & ~m_srcq);
    m_srcq = src;
    @(negedge clk);
    #1;
  endtask

  task automatic check(string tag);
    bit bad = 0;
    tests++;
    if (pend !== m_pend) begin
      $display("FAIL %s pend_o act=%h exp=%h", tag, pend, m_pend); bad = 1;
    end
    if (status !== m_srcq) begin
      $display("FAIL %s status_o act=%h exp=%h", tag, status, m_srcq); bad = 1;
    end
    if (snap !== m_snap) begin
      $display("FAIL %s snap_o act=%h exp=%h", tag, snap, m_snap); bad = 1;
    end
    if (irq_n !== exp_irq_n()) begin
      $display("FAIL %s irq_no act=%b exp=%b", tag, irq_n, exp_irq_n()); bad = 1;
    end
    if (bad) fails++;
  endtask

  task automatic idle();
    rd_all = 0; rd_grp = '0; snap_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset");
    rst_n = 1'b1;
    cyc();
    check("R11 after release");

    // sweep every source through edge, enables, clear, fall
    for (int i = 0; i < SN; i++) begin
      int g = i / GW;
      src[i] = 1'b1;
      cyc(); check("R1 rising edge latch");
      cyc(); check("R2 held high no set");
      for (int c = 0; c < 4; c++) begin
        grp_en = '0; src_en = '0;
        grp_en[g] = c[0]; src_en[i] = c[1];
        cyc();
        check(c == 3 ? "R3 both enables" : (c[0] ? "R5 source masked" : "R4 group masked"));
      end
      if (i % 2 == 0) rd_grp[g] = 1'b1; else rd_all = 1'b1;
      cyc(); idle();
      check(i % 2 == 0 ? "R7 group clear" : "R6 clear all");
      src[i] = 1'b0;
      cyc(); check("R2 falling no set");
      grp_en = '0; src_en = '0;
    end

    // R7: group clear leaves other groups
    src = {GN{8'h81}};
    cyc(); src = '0;
    rd_grp = 3'b010;
    cyc(); idle();
    check("R7 other groups kept");
    rd_all = 1'b1;
    cyc(); idle();
    check("R6 clear remaining");

    // R8: event in the clearing cycle
    src[5] = 1'b1; src[17] = 1'b1;
    cyc();
    src[9] = 1'b1; rd_all = 1'b1;
    cyc(); idle();
    check("R8 event during read-all");
    src[20] = 1'b1; rd_grp = 3'b100;
    cyc(); idle();
    check("R8 event during group read");
    rd_all = 1'b1;
    cyc(); idle();
    src = '0;
    cyc(); check("R8 cleanup");

    // R9: status with everything masked
    grp_en = '0; src_en = '0;
    src = 24'hA5C3_3C;
    cyc(); check("R9 status follows level");
    src = 24'h0F_F00F;
    cyc(); check("R9 status follows change");
    rd_all = 1'b1;
    cyc(); idle();
    src = '0;
    cyc(); rd_all = 1'b1; cyc(); idle();
    check("R9 cleanup");

    // R12 and R10: masked latch, then enable, then snapshot
    src[14] = 1'b1;
    cyc(); check("R12 masked still latches");
    grp_en = 3'b010; src_en[14] = 1'b1;
    cyc(); check("R12 enabled after latch");
    snap_rd = 1'b1;
    cyc(); idle();
    check("R10 snapshot no clear");
    cyc(); check("R10 irq held after snapshot");
    rd_grp = 3'b010;
    cyc(); idle();
    check("R3 released by read");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule